// File: doc/BRIEF.md
# Interrupt Status and Enable Controller

This block is the interrupt front end of a bus controller. Eight source conditions arrive as one-cycle pulses or held levels on `evt_i`. Each source that is high sets its own sticky bit in a status register. Software clears a status bit only by writing a one to it.

An enable register selects which status bits may raise the interrupt. A single global-enable bit gates the output line. `irq_o` goes high when the global enable is on and at least one enabled status bit is set.

A key-protected reset register completes the set. A write of the key value produces a one-cycle soft-reset pulse for the surrounding controller, and that pulse also clears this block's own registers. All four registers sit behind a simple 32-bit register read/write port, and read data is registered.

Top module: `irq_front_end`

## Requirements
- R1: After a synchronous reset, the status, enable and global-enable registers read 0, and `irq_o`, `soft_rst_o` and `rdata_o` are 0.
- R2: A high `evt_i[n]` sets status bit n at the next clock edge. The status register is read at offset 0x20 in bits 7:0, with bits 31:8 reading 0. The bit meanings are: 0 arbitration lost, 1 transmit error or transfer done, 2 transmit queue empty, 3 receive queue at threshold, 4 bus idle, 5 addressed as target, 6 no longer addressed as target, 7 transmit queue half empty. A set bit stays set until it is cleared as R3 describes.
- R3: A write to offset 0x20 clears every status bit whose `wdata_i` bit is 1 and leaves the bits written with 0 unchanged.
- R4: When an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: The enable register at offset 0x28 stores `wdata_i[7:0]` on a write. It reads back in bits 7:0, and bits 31:8 read 0.
- R6: The global enable at offset 0x1C is bit 31. It stores `wdata_i[31]` on a write and reads back as `{ge,31'b0}`.
- R7: `irq_o` is registered. After the edge that follows a cycle in which the global enable is 1 and (status AND enable) is nonzero, `irq_o` is 1. Otherwise it is 0.
- R8: A write of 0x0000000A to offset 0x40 makes `soft_rst_o` high for exactly the cycle after the write. At the next edge, status, enable and global enable clear to 0, and any event or write in that cycle is dropped.
- R9: A write of any other value to offset 0x40 produces no pulse and changes no register.
- R10: When `rd_en_i` is high, `rdata_o` takes the addressed register's value at the next edge. Offset 0x40 and unmapped offsets read 0. When `rd_en_i` is low, `rdata_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 8 | Source conditions, one per status bit |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Registered interrupt line |
| soft_rst_o | output | 1 | One-cycle soft-reset pulse |

## Verification
The directed part uses single-bit and multi-bit event pulses against masks that differ in which bits are enabled. This shows whether the AND with the enable register is taken per bit, and whether the global enable gates the line independently of the mask. Clearing writes with mixed ones and zeros, and a collision between an event and a clear on the same bit, separate correct write-one-to-clear from plain overwrite and show which side wins. Keyed and non-keyed writes to the reset offset, followed by read-back of the enable register, separate the accepted key from ignored values. A long stretch of random events, writes and reads is then compared clock by clock against a behavioural model.

// File: rtl/irq_fe_pkg.sv
package irq_fe_pkg;
  localparam logic [7:0] OFS_GE  = 8'h1C;
  localparam logic [7:0] OFS_ST  = 8'h20;
  localparam logic [7:0] OFS_EN  = 8'h28;
  localparam logic [7:0] OFS_KEY = 8'h40;
  localparam logic [31:0] KEY_VAL = 32'h0000_000A;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int SRC_N = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_all,
  input  logic [SRC_N-1:0] evt_i,
  input  logic             w1c_en,
  input  logic [SRC_N-1:0] w1c_mask,
  output logic [SRC_N-1:0] st_o
);
  logic [SRC_N-1:0] st_q;

  for (genvar b = 0; b < SRC_N; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || clr_all)
        st_q[b] <= 1'b0;
      else if (evt_i[b])
        st_q[b] <= 1'b1;
      else if (w1c_en && w1c_mask[b])
        st_q[b] <= 1'b0;
    end
  end

  assign st_o = st_q;

  // R2
  st_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!w1c_en && !clr_all) |=> ((st_q & $past(st_q)) == $past(st_q)));

  // R4
  evt_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_all) |=> ((st_q & $past(evt_i)) == $past(evt_i)));
endmodule

// File: rtl/irq_enable_regs.sv
module irq_enable_regs #(
  parameter int SRC_N = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_all,
  input  logic             en_we,
  input  logic [SRC_N-1:0] en_wdata,
  input  logic             ge_we,
  input  logic             ge_wdata,
  output logic [SRC_N-1:0] en_o,
  output logic             ge_o
);
  logic [SRC_N-1:0] en_q;
  logic             ge_q;

  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      en_q <= '0;
      ge_q <= 1'b0;
    end else begin
      if (en_we) en_q <= en_wdata;
      if (ge_we) ge_q <= ge_wdata;
    end
  end

  assign en_o = en_q;
  assign ge_o = ge_q;

  // R5
  en_store_chk: assert property (@(posedge clk) disable iff (rst)
    (en_we && !clr_all) |=> (en_q == $past(en_wdata)));

  // R6
  ge_store_chk: assert property (@(posedge clk) disable iff (rst)
    (ge_we && !clr_all) |=> (ge_q == $past(ge_wdata)));
endmodule

// File: rtl/irq_key_reset.sv
module irq_key_reset #(
  parameter int          DATA_W = 32,
  parameter logic [31:0] KEY    = 32'h0000_000A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_we,
  input  logic [DATA_W-1:0] wdata,
  output logic              pulse_o
);
  localparam logic [DATA_W-1:0] KEY_W = DATA_W'(KEY);
  logic pulse_q;

  always_ff @(posedge clk) begin
    if (rst) pulse_q <= 1'b0;
    else     pulse_q <= key_we && (wdata == KEY_W);
  end

  assign pulse_o = pulse_q;

  // R8
  key_only_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_q |-> $past(key_we && (wdata == KEY_W)));

  // R9
  bad_key_chk: assert property (@(posedge clk) disable iff (rst)
    (key_we && (wdata != KEY_W)) |=> !pulse_q);
endmodule

// File: rtl/irq_front_end.sv
module irq_front_end #(
  parameter int DATA_W = 32,
  parameter int SRC_N  = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SRC_N-1:0]  evt_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              soft_rst_o
);
  import irq_fe_pkg::*;

  localparam int GE_BIT = DATA_W - 1;
  localparam int PAD_W  = DATA_W - SRC_N;
  localparam logic [ADDR_W-1:0] A_GE  = ADDR_W'(OFS_GE);
  localparam logic [ADDR_W-1:0] A_ST  = ADDR_W'(OFS_ST);
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(OFS_EN);
  localparam logic [ADDR_W-1:0] A_KEY = ADDR_W'(OFS_KEY);

  logic [SRC_N-1:0]  st, en;
  logic              ge;
  logic              clr_all;
  logic [DATA_W-1:0] rd_q, rd_mux;
  logic              irq_q;

  assign clr_all = soft_rst_o;

  irq_status_bank #(.SRC_N(SRC_N)) u_status (
    .clk(clk), .rst(rst), .clr_all(clr_all), .evt_i(evt_i),
    .w1c_en(wr_en_i && (addr_i == A_ST)),
    .w1c_mask(wdata_i[SRC_N-1:0]),
    .st_o(st)
  );

  irq_enable_regs #(.SRC_N(SRC_N)) u_enable (
    .clk(clk), .rst(rst), .clr_all(clr_all),
    .en_we(wr_en_i && (addr_i == A_EN)),
    .en_wdata(wdata_i[SRC_N-1:0]),
    .ge_we(wr_en_i && (addr_i == A_GE)),
    .ge_wdata(wdata_i[GE_BIT]),
    .en_o(en), .ge_o(ge)
  );

  irq_key_reset #(.DATA_W(DATA_W), .KEY(KEY_VAL)) u_key (
    .clk(clk), .rst(rst),
    .key_we(wr_en_i && (addr_i == A_KEY)),
    .wdata(wdata_i),
    .pulse_o(soft_rst_o)
  );

  always_comb begin
    rd_mux = '0;
    if (addr_i == A_ST)      rd_mux = {{PAD_W{1'b0}}, st};
    else if (addr_i == A_EN) rd_mux = {{PAD_W{1'b0}}, en};
    else if (addr_i == A_GE) rd_mux[GE_BIT] = ge;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      if (rd_en_i) rd_q <= rd_mux;
      irq_q <= ge && |(st & en);
    end
  end

  assign rdata_o = rd_q;
  assign irq_o   = irq_q;

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(ge && |(st & en)));

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> $stable(rd_q));
endmodule

// File: tb/tb_irq_front_end.sv
module tb_irq_front_end;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  evt = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, srst;

  int vectors = 0, errs = 0;

  irq_front_end dut (
    .clk(clk), .rst(rst), .evt_i(evt), .wr_en_i(wr), .rd_en_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
    .soft_rst_o(srst)
  );

  always #10 clk = ~clk;

  // behavioural reference
  logic [7:0]  m_st, m_en;
  logic        m_ge, m_irq, m_soft;
  logic [31:0] m_rd;

  function automatic logic [31:0] m_read(input logic [7:0] a);
    if (a == 8'h20) return {24'b0, m_st};
    if (a == 8'h28) return {24'b0, m_en};
    if (a == 8'h1C) return {m_ge, 31'b0};
    return 32'b0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st <= 0; m_en <= 0; m_ge <= 0; m_irq <= 0; m_soft <= 0; m_rd <= 0;
    end else begin
      m_irq  <= m_ge && ((m_st & m_en) != 0);
      m_soft <= wr && addr == 8'h40 && wdata == 32'hA;
      if (rd) m_rd <= m_read(addr);
      if (m_soft) begin
        m_st <= 0; m_en <= 0; m_ge <= 0;
      end else begin
        m_st <= (m_st & ~((wr && addr == 8'h20) ? wdata[7:0] : 8'h00)) | evt;
        if (wr && addr == 8'h28) m_en <= wdata[7:0];
        if (wr && addr == 8'h1C) m_ge <= wdata[31];
      end
    end
  end

  // clock-by-clock comparison away from the edge
  always @(negedge clk) begin
    if (!rst) begin
      vectors++;
      if (irq !== m_irq || srst !== m_soft || rdata !== m_rd) begin
        errs++;
        $display("FAIL R7/R8/R10 model: irq=%0b/%0b soft=%0b/%0b rdata=%h/%h",
                 irq, m_irq, srst, m_soft, rdata, m_rd);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wreg(input logic [7:0] a, input logic [31:0] d, input logic [7:0] e = 8'h00);
    wr = 1; addr = a; wdata = d; evt = e;
    @(negedge clk);
    wr = 0; evt = 0;
  endtask

  task automatic rreg(input logic [7:0] a, input logic [31:0] exp, input string tag);
    rd = 1; addr = a;
    @(negedge clk);
    rd = 0;
    chk(tag, rdata, exp);
  endtask

  task automatic pulse(input logic [7:0] e);
    evt = e;
    @(negedge clk);
    evt = 0;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle(3);
    rst = 0;
    @(negedge clk);
    // R1
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 soft", {31'b0, srst}, 0);
    rreg(8'h20, 0, "R1 status");
    rreg(8'h28, 0, "R1 enable");
    rreg(8'h1C, 0, "R1 ge");
    // R2
    pulse(8'h81);
    rreg(8'h20, 32'h81, "R2 set");
    idle(3);
    rreg(8'h20, 32'h81, "R2 sticky");
    // R3
    wreg(8'h20, 32'hFFFF_FF01);
    rreg(8'h20, 32'h80, "R3 w1c");
    // R4
    wreg(8'h20, 32'h80, 8'h80);
    rreg(8'h20, 32'h80, "R4 event wins");
    wreg(8'h20, 32'hFF);
    rreg(8'h20, 0, "R3 clear all");
    // R5
    wreg(8'h28, 32'hFFFF_FF5A);
    rreg(8'h28, 32'h5A, "R5 enable");
    // R6
    wreg(8'h1C, 32'hFFFF_FFFF);
    rreg(8'h1C, 32'h8000_0000, "R6 ge");
    // R7: enabled bit 1
    pulse(8'h02);
    @(negedge clk);
    chk("R7 irq on", {31'b0, irq}, 1);
    wreg(8'h20, 32'h02);
    @(negedge clk);
    chk("R7 irq off after clear", {31'b0, irq}, 0);
    pulse(8'h01);
    idle(2);
    chk("R7 masked source", {31'b0, irq}, 0);
    pulse(8'h08);
    @(negedge clk);
    chk("R7 enabled source", {31'b0, irq}, 1);
    wreg(8'h1C, 32'h7FFF_FFFF);
    @(negedge clk);
    chk("R7 global gate", {31'b0, irq}, 0);
    wreg(8'h1C, 32'h8000_0000);
    // R8
    wreg(8'h40, 32'hA);
    chk("R8 pulse", {31'b0, srst}, 1);
    @(negedge clk);
    chk("R8 single", {31'b0, srst}, 0);
    rreg(8'h20, 0, "R8 status cleared");
    rreg(8'h28, 0, "R8 enable cleared");
    rreg(8'h1C, 0, "R8 ge cleared");
    // R9
    wreg(8'h28, 32'h33);
    wreg(8'h40, 32'h5);
    chk("R9 no pulse", {31'b0, srst}, 0);
    wreg(8'h40, 32'h1_000A);
    chk("R9 no pulse wide", {31'b0, srst}, 0);
    rreg(8'h28, 32'h33, "R9 enable kept");
    // R10
    rreg(8'h40, 0, "R10 key reads 0");
    rreg(8'h30, 0, "R10 unmapped");
    idle(2);
    chk("R10 hold", rdata, 0);
    // random phase against model
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      evt = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00;
      wr = (r < 30);
      rd = (r >= 30 && r < 60);
      case ($urandom_range(0, 4))
        0: addr = 8'h20;
        1: addr = 8'h28;
        2: addr = 8'h1C;
        3: addr = 8'h40;
        default: addr = 8'h24;
      endcase
      wdata = (addr == 8'h40 && $urandom_range(0, 3) == 0) ? 32'hA : $urandom;
      if (addr == 8'h40 && wdata == 32'hA && $urandom_range(0, 3) != 0) wr = 0;
      @(negedge clk);
    end
    wr = 0; rd = 0; evt = 0;
    idle(2);
    finish_run();
  end
endmodule